// File: doc/BRIEF.md
# Ramp-Aligned Multichannel Sample Capture Memory

This block records the digitized beat signals of a multichannel FMCW receiver into an on-chip memory laid out as a cube: receive channel by ramp by sample. The words from all receive channels arrive together, qualified by one shared valid strobe. They are written in parallel, one memory bank per channel. Every rising edge of the transmit ramp trigger realigns the sample counter. As a result, sample k of every ramp always lands at the same offset, whatever the sampling rate or the gaps between valid strobes.

The host first sets the number of samples per ramp and the number of ramps per frame, then pulses `arm`. The first trigger edge after arming opens ramp 0. Each later edge moves to the next ramp. Once the last sample of the last ramp is stored, capture stops and `frame_done` is raised. A bridge processor then reads the cube through an independent registered read port. A trigger that arrives before a ramp has collected its full sample count is flagged in a sticky error bit. The next `arm` clears both flags.

Top module: `frame_logger`

## Requirements
- R1: After reset `frame_done` and `short_err` are 0, and triggers and samples arriving before the first `arm` start no capture, so `frame_done` stays 0.
- R2: The words of all channels presented in one valid cycle are stored together. The read address is {channel, ramp, sample}: the channel in the top `$clog2(NUM_CH)` bits, the ramp in the next `RAMP_AW` bits and the sample in the low `SAMP_AW` bits. Channel c's word sits at `samp_data[c*SAMPLE_W +: SAMPLE_W]`.
- R3: The sample index returns to 0 on every trigger rising edge. A valid word in the same cycle as that edge is stored as sample 0.
- R4: The first trigger rising edge after `arm` opens ramp 0, and each later edge advances the ramp index by one.
- R5: Valid words that arrive after `cfg_samples` words of the current ramp and before the next trigger are dropped. The memory at those offsets keeps its earlier content.
- R6: Only cycles with `samp_valid` high store a word. Idle cycles between valid strobes, at any spacing, do not advance the sample index.
- R7: When the last sample of ramp `cfg_ramps-1` is written, `frame_done` becomes 1 at the next clock edge. It then stays 1, and no further trigger or sample changes the memory until the next `arm`.
- R8: `arm` clears `frame_done` and `short_err` at the next edge. Capture then begins only on a trigger rising edge, so a trigger level already high at arm time starts nothing.
- R9: A trigger rising edge during capture, before the current ramp holds `cfg_samples` words, sets `short_err`. The bit stays 1 until `arm`, and the next ramp still starts at sample 0.
- R10: `rd_data` presents the word at `rd_addr` one cycle after `rd_en` is sampled high.
- R11: A short trigger on the final ramp ends the frame. `frame_done` and `short_err` both become 1 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Host pulse: clear flags and wait for a trigger edge |
| trig | input | 1 | Transmit ramp trigger level |
| samp_valid | input | 1 | Qualifies `samp_data` for all channels |
| samp_data | input | NUM_CH*SAMPLE_W | Packed sample words, channel 0 in the low bits |
| cfg_samples | input | SAMP_AW+1 | Samples kept per ramp, 1 to 2**SAMP_AW |
| cfg_ramps | input | RAMP_AW+1 | Ramps per frame, 1 to 2**RAMP_AW |
| rd_en | input | 1 | Read request |
| rd_addr | input | $clog2(NUM_CH)+RAMP_AW+SAMP_AW | Read address {channel, ramp, sample} |
| rd_data | output | SAMPLE_W | Read word, valid one cycle after `rd_en` |
| frame_done | output | 1 | Frame complete, capture halted |
| short_err | output | 1 | Sticky: a ramp ended before its sample count was reached |

## Verification
Each stimulus is applied on a falling clock edge and its result is due after exactly one rising edge. A word offered with `samp_valid` is in memory after that edge. `frame_done` and `short_err` change at the edge that consumes the last sample, the early trigger or the `arm` pulse. `rd_data` follows one edge after `rd_en`. The bench reads every result on the falling edge after that single rising edge, never on the edge itself. It compares what it reads against a shadow copy of the cube, and that copy is filled from the requirements for each address the bench expects to be written.

// File: rtl/flog_pkg.sv
package flog_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_CAPT  = 2'd2,
      ST_DONE  = 2'd3
   } flog_state_e;
endpackage

// File: rtl/flog_bank.sv
module flog_bank #(
   parameter int DATA_W = 14,
   parameter int AW     = 7
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/flog_ctrl.sv
module flog_ctrl
   import flog_pkg::*;
#(
   parameter int SAMP_AW = 4,
   parameter int RAMP_AW = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       arm,
   input  logic                       trig,
   input  logic                       samp_valid,
   input  logic [SAMP_AW:0]           cfg_samples,
   input  logic [RAMP_AW:0]           cfg_ramps,
   output logic                       wr_en,
   output logic [RAMP_AW+SAMP_AW-1:0] wr_addr,
   output logic                       frame_done,
   output logic                       short_err
);
   localparam int SW1 = SAMP_AW + 1;
   localparam int RW1 = RAMP_AW + 1;

   flog_state_e    state_q, state_d;
   logic           trig_q, trig_rise;
   logic [SW1-1:0] samp_q, samp_eff;
   logic [RW1-1:0] ramp_q, ramp_eff, last_ramp;
   logic           hit_short, end_frame, fill_done;

   assign trig_rise = trig & ~trig_q;
   assign last_ramp = cfg_ramps - RW1'(1);

   always_comb begin
      ramp_eff  = ramp_q;
      samp_eff  = samp_q;
      wr_en     = 1'b0;
      hit_short = 1'b0;
      end_frame = 1'b0;
      unique case (state_q)
         ST_ARMED: begin
            if (trig_rise) begin
               ramp_eff = '0;
               samp_eff = '0;
               wr_en    = samp_valid;
            end
         end
         ST_CAPT: begin
            if (trig_rise) begin
               hit_short = (samp_q < cfg_samples);
               if (ramp_q == last_ramp) begin
                  end_frame = 1'b1;
               end else begin
                  ramp_eff = ramp_q + RW1'(1);
                  samp_eff = '0;
                  wr_en    = samp_valid;
               end
            end else begin
               wr_en = samp_valid && (samp_q < cfg_samples);
            end
         end
         default: ;
      endcase
   end

   assign fill_done = wr_en && ((samp_eff + SW1'(1)) == cfg_samples)
                      && (ramp_eff == last_ramp);
   assign wr_addr   = {ramp_eff[RAMP_AW-1:0], samp_eff[SAMP_AW-1:0]};

   always_comb begin
      state_d = state_q;
      if (arm) begin
         state_d = ST_ARMED;
      end else if (fill_done || end_frame) begin
         state_d = ST_DONE;
      end else if (state_q == ST_ARMED && trig_rise) begin
         state_d = ST_CAPT;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         trig_q    <= 1'b0;
         samp_q    <= '0;
         ramp_q    <= '0;
         short_err <= 1'b0;
      end else begin
         state_q   <= state_d;
         trig_q    <= trig;
         samp_q    <= samp_eff + SW1'(wr_en);
         ramp_q    <= ramp_eff;
         short_err <= arm ? 1'b0 : (short_err | hit_short);
      end
   end

   assign frame_done = (state_q == ST_DONE);

   // R5
   samp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CAPT) |-> (samp_q <= cfg_samples));
   // R7
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !arm) |=> frame_done);
   // R9
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(short_err) |-> $past(trig_rise && state_q == ST_CAPT));
   // R8
   arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (!short_err && !frame_done));
endmodule

// File: rtl/frame_logger.sv
module frame_logger #(
   parameter int NUM_CH   = 8,
   parameter int SAMPLE_W = 14,
   parameter int SAMP_AW  = 4,
   parameter int RAMP_AW  = 3,
   localparam int CH_W    = $clog2(NUM_CH),
   localparam int LOC_W   = RAMP_AW + SAMP_AW,
   localparam int ADDR_W  = CH_W + LOC_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       arm,
   input  logic                       trig,
   input  logic                       samp_valid,
   input  logic [NUM_CH*SAMPLE_W-1:0] samp_data,
   input  logic [SAMP_AW:0]           cfg_samples,
   input  logic [RAMP_AW:0]           cfg_ramps,
   input  logic                       rd_en,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [SAMPLE_W-1:0]        rd_data,
   output logic                       frame_done,
   output logic                       short_err
);
   if (NUM_CH < 2 || (1 << CH_W) != NUM_CH) begin : g_bad_ch
      $error("NUM_CH must be a power of two of at least 2");
   end
   if (SAMPLE_W < 1 || SAMP_AW < 1 || RAMP_AW < 1) begin : g_bad_w
      $error("SAMPLE_W, SAMP_AW and RAMP_AW must be at least 1");
   end

   logic                wr_en;
   logic [LOC_W-1:0]    wr_addr;
   logic [CH_W-1:0]     rd_ch_q;
   logic [SAMPLE_W-1:0] bank_rd [NUM_CH];

   flog_ctrl #(.SAMP_AW(SAMP_AW), .RAMP_AW(RAMP_AW)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm         (arm),
      .trig        (trig),
      .samp_valid  (samp_valid),
      .cfg_samples (cfg_samples),
      .cfg_ramps   (cfg_ramps),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .frame_done  (frame_done),
      .short_err   (short_err)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
      flog_bank #(.DATA_W(SAMPLE_W), .AW(LOC_W)) u_bank (
         .clk   (clk),
         .we    (wr_en),
         .waddr (wr_addr),
         .wdata (samp_data[c*SAMPLE_W +: SAMPLE_W]),
         .re    (rd_en),
         .raddr (rd_addr[LOC_W-1:0]),
         .rdata (bank_rd[c])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_ch_q <= '0;
      else if (rd_en) rd_ch_q <= rd_addr[ADDR_W-1 -: CH_W];
   end

   assign rd_data = bank_rd[rd_ch_q];

   // R7
   no_write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !wr_en);
   // R10
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rd_en) && !$past(wr_en)) |-> $stable(rd_data));
endmodule

// File: tb/frame_logger_tb.sv
module frame_logger_tb;
   localparam int CLK_P = 10;
   localparam int NCH   = 8;
   localparam int SW    = 14;
   localparam int SAW   = 4;
   localparam int RAW   = 3;
   localparam int AW    = 3 + RAW + SAW;
   localparam int DEPTH = 1 << AW;
   // samples, ramps, gap cycles between valid words, run id
   localparam int SCN [4][4] = '{'{16, 8, 0, 1}, '{10, 4, 3, 2},
                                  '{ 1, 1, 0, 3}, '{ 5, 8, 1, 4}};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              arm = 1'b0, trig = 1'b0, samp_valid = 1'b0, rd_en = 1'b0;
   logic [NCH*SW-1:0] samp_data = '0;
   logic [SAW:0]      cfg_samples = '0;
   logic [RAW:0]      cfg_ramps = '0;
   logic [AW-1:0]     rd_addr = '0;
   logic [SW-1:0]     rd_data;
   logic              frame_done, short_err;

   logic [SW-1:0]     exp_mem [DEPTH];
   bit                exp_v   [DEPTH];
   int                n_chk = 0, n_err = 0;

   always #(CLK_P/2) clk = ~clk;

   frame_logger u_dut (
      .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig), .samp_valid(samp_valid),
      .samp_data(samp_data), .cfg_samples(cfg_samples), .cfg_ramps(cfg_ramps),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .frame_done(frame_done), .short_err(short_err));

   function automatic logic [SW-1:0] pat(int run, int ch, int ramp, int s);
      return {4'(run), 3'(ch), 3'(ramp), 4'(s)};
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_arm();
      @(negedge clk) arm = 1'b1;
      @(negedge clk) arm = 1'b0;
   endtask

   // trigger edge with the first word, then nsend words; first nkeep expected stored
   task automatic send_ramp(int run, int ramp, int nsend, int nkeep, int gap, bit store);
      for (int k = 0; k < nsend; k++) begin
         @(negedge clk);
         trig = (k == 0);
         samp_valid = 1'b1;
         for (int c = 0; c < NCH; c++) begin
            samp_data[c*SW +: SW] = pat(run, c, ramp, k);
            if (store && k < nkeep) begin
               exp_mem[{3'(c), RAW'(ramp), SAW'(k)}] = pat(run, c, ramp, k);
               exp_v[{3'(c), RAW'(ramp), SAW'(k)}]   = 1'b1;
            end
         end
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            trig = 1'b0;
            samp_valid = 1'b0;
         end
      end
      @(negedge clk);
      trig = 1'b0;
      samp_valid = 1'b0;
   endtask

   task automatic readback(input string req);
      for (int a = 0; a < DEPTH; a++) begin
         if (exp_v[a]) begin
            @(negedge clk);
            rd_en = 1'b1;
            rd_addr = AW'(a);
            @(negedge clk);
            rd_en = 1'b0;
            check(req, int'(rd_data), int'(exp_mem[a]));
         end
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int a = 0; a < DEPTH; a++) exp_v[a] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 done after reset", int'(frame_done), 0);
      check("R1 err after reset", int'(short_err), 0);

      // R1: activity before any arm starts nothing
      cfg_samples = 2;
      cfg_ramps = 1;
      send_ramp(15, 0, 3, 0, 0, 1'b0);
      check("R1 no capture before arm", int'(frame_done), 0);

      // table walk: R2 R3 R4 R5 R6 R7 R10
      for (int i = 0; i < 4; i++) begin
         cfg_samples = (SAW+1)'(SCN[i][0]);
         cfg_ramps   = (RAW+1)'(SCN[i][1]);
         do_arm();
         check("R8 done cleared by arm", int'(frame_done), 0);
         for (int r = 0; r < SCN[i][1]; r++) begin
            if (r == SCN[i][1] - 1)
               check("R7 not done before last ramp", int'(frame_done), 0);
            send_ramp(SCN[i][3], r, SCN[i][0] + 2, SCN[i][0], SCN[i][2], 1'b1);
         end
         check("R7 done after last ramp", int'(frame_done), 1);
         check("R9 no error on full ramps", int'(short_err), 0);
         send_ramp(SCN[i][3] + 8, 0, 3, 0, 0, 1'b0);
         check("R7 done holds", int'(frame_done), 1);
         readback("R2/R3/R4/R5/R6/R7/R10 readback");
      end

      // R9: short first ramp, sticky error, restart of sample index
      cfg_samples = 8;
      cfg_ramps = 4;
      do_arm();
      send_ramp(5, 0, 3, 3, 0, 1'b1);
      check("R9 no error yet", int'(short_err), 0);
      send_ramp(5, 1, 8, 8, 0, 1'b1);
      check("R9 error set", int'(short_err), 1);
      send_ramp(5, 2, 8, 8, 0, 1'b1);
      send_ramp(5, 3, 8, 8, 0, 1'b1);
      check("R9 done after short ramp", int'(frame_done), 1);
      check("R9 error sticky", int'(short_err), 1);
      readback("R9/R3 readback");
      do_arm();
      check("R8 arm clears error", int'(short_err), 0);
      check("R8 arm clears done", int'(frame_done), 0);

      // R11: short trigger on final ramp ends the frame
      cfg_ramps = 2;
      send_ramp(6, 0, 8, 8, 0, 1'b1);
      send_ramp(6, 1, 2, 2, 1, 1'b1);
      check("R11 not done mid ramp", int'(frame_done), 0);
      @(negedge clk) trig = 1'b1;
      @(negedge clk) trig = 1'b0;
      check("R11 done on short last ramp", int'(frame_done), 1);
      check("R11 error on short last ramp", int'(short_err), 1);
      readback("R11 readback");

      // R8: trigger level already high at arm starts nothing
      cfg_samples = 2;
      cfg_ramps = 1;
      @(negedge clk) trig = 1'b1;
      do_arm();
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         samp_valid = 1'b1;
         for (int c = 0; c < NCH; c++) samp_data[c*SW +: SW] = pat(9, c, 0, k);
      end
      @(negedge clk);
      samp_valid = 1'b0;
      trig = 1'b0;
      @(negedge clk);
      check("R8 level trigger ignored", int'(frame_done), 0);
      send_ramp(7, 0, 2, 2, 0, 1'b1);
      check("R8 capture on next edge", int'(frame_done), 1);
      readback("R8/R2 readback");

      finish_run();
   end
endmodule